// File: doc/BRIEF.md
# SPI Framed Response Serializer

This block sits between a command processor and an SPI slave shifter and produces the byte stream the slave shifts out once a command has been handled. The host clocks bytes blindly and scans for a frame marker, so every response opens with padding bytes and a frame-start byte. After the marker comes either a legacy frame or a packet-format frame. The legacy frame carries a status byte, a length byte, the payload and an 8-bit additive checksum. The packet-format frame carries the packet bytes taken straight from the buffer. Both formats end with a past-end byte, and that byte keeps repeating for as long as the host goes on reading.

The command side starts a response with a one-cycle pulse. With that pulse it gives the format, the status and the payload length. The payload stays in an external byte buffer. The block reads that buffer through an address output and a data input that returns data one cycle after the address. The shifter asks for each byte with a one-cycle request, and the block answers in the next cycle with a byte and a valid strobe. When chip select rises, any response in progress is dropped.

Top module: `rsp_frame_ser`

## Requirements
- R1: After reset, `byte_vld_o` and `active_o` are low.
- R2: A legacy response (`fmt_i`=0) yields, one byte per request, 0xFA, 0xEC, the status, the low 8 bits of the length, the payload bytes in buffer address order starting at address 0, the checksum, and then 0xED.
- R3: The legacy checksum is the low 8 bits of the sum of the status byte sent, the length byte sent and every payload byte. The pad byte and the frame-start byte are not counted.
- R4: A packet-format response (`fmt_i`=1) yields 0xFA, 0xFA, 0xFA, 0xEC, the payload bytes in address order, and then 0xED. It has no status, length or checksum byte.
- R5: After the past-end byte has been sent, every further request returns 0xED until the response is aborted.
- R6: A start pulse is accepted only while the block is idle, `rx_busy_i` is high and `cs_high_i` is low. An ignored start leaves `active_o` low and produces no bytes.
- R7: A length above 544 counts as oversize. For an oversize legacy response the status byte is sent as 0x0C and the length byte as 0, with no payload. For an oversize packet-format response no payload bytes are sent. A length of exactly 544 is served in full.
- R8: When `cs_high_i` is high in a cycle, the block is idle in the next cycle, a request made in that same cycle yields no byte, and later requests yield nothing.
- R9: Each byte appears with `byte_vld_o` in the cycle after its request. Requests made in consecutive cycles are each served.
- R10: While idle, requests produce no valid byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that begins a response |
| fmt_i | input | 1 | 0 selects legacy framing, 1 selects packet framing |
| status_i | input | 8 | Result code for a legacy response |
| len_i | input | LEN_W | Payload length in bytes |
| rx_busy_i | input | 1 | High while the receive side is still processing the command |
| cs_high_i | input | 1 | Chip select deasserted; aborts the response |
| next_i | input | 1 | Shifter requests the next byte |
| rd_addr_o | output | LEN_W | Payload buffer address |
| rd_data_i | input | 8 | Buffer data, one cycle after the address |
| byte_o | output | 8 | Byte to shift out |
| byte_vld_o | output | 1 | `byte_o` holds a new byte |
| active_o | output | 1 | A response is in progress |

## Verification
Each byte is due exactly one cycle after the request that asked for it, because one register stage sits between the request and `byte_o`. Payload bytes come through the buffer's one-cycle read in that same cycle. The bench drives requests on the falling edge and reads the byte on the next falling edge, so each sample falls in the cycle the byte is due. Acceptance of a start is checked on the falling edge right after the pulse. An abort is checked on the falling edge after `cs_high_i` was high. The bench sweeps both formats over a range of lengths, with dense and spaced requests, and builds the expected stream and checksum arithmetically from a buffer model.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    localparam logic [7:0] BYTE_PAD  = 8'hFA;
    localparam logic [7:0] BYTE_FRM  = 8'hEC;
    localparam logic [7:0] BYTE_END  = 8'hED;
    localparam logic [7:0] ST_BADRSP = 8'h0C;

    localparam int LEGACY_PADS = 1;
    localparam int PACKET_PADS = 3;

    typedef enum logic {
        FMT_LEGACY = 1'b0,
        FMT_PACKET = 1'b1
    } fmt_e;

    typedef enum logic [3:0] {
        PH_IDLE, PH_PAD, PH_FRM, PH_STAT, PH_LEN,
        PH_PAY, PH_SUM, PH_END, PH_TAIL
    } phase_e;

    typedef enum logic [2:0] {
        K_PAD, K_FRM, K_STAT, K_LEN, K_PAY, K_SUM, K_END
    } kind_e;

    typedef struct packed {
        logic  vld;
        kind_e kind;
    } out_tag_t;

    function automatic logic [7:0] const_byte(kind_e k, logic [7:0] st, logic [7:0] ln);
        case (k)
            K_PAD:   return BYTE_PAD;
            K_FRM:   return BYTE_FRM;
            K_STAT:  return st;
            K_LEN:   return ln;
            default: return BYTE_END;
        endcase
    endfunction

endpackage

// File: rtl/rsp_csum.sv
module rsp_csum (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic [7:0] init_i,
    input  logic       add_i,
    input  logic [7:0] data_i,
    output logic [7:0] sum_o
);
    logic [7:0] sum_q;

    always_ff @(posedge clk) begin
        if (rst)         sum_q <= '0;
        else if (load_i) sum_q <= init_i;
        else if (add_i)  sum_q <= sum_q + data_i;
    end

    assign sum_o = sum_q;
endmodule

// File: rtl/rsp_seq.sv
module rsp_seq
    import rsp_pkg::*;
#(
    parameter int MAX_LEN = 544,
    parameter int LEN_W   = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             fmt_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             rx_busy_i,
    input  logic             cs_high_i,
    input  logic             next_i,
    output logic             accept_o,
    output logic             oversize_o,
    output out_tag_t         tag_o,
    output logic [LEN_W-1:0] idx_o,
    output logic [LEN_W-1:0] len_o,
    output fmt_e             fmt_o,
    output logic             active_o
);
    localparam logic [1:0] LEG_PAD_LAST = 2'(LEGACY_PADS - 1);
    localparam logic [1:0] PKT_PAD_LAST = 2'(PACKET_PADS - 1);

    phase_e           ph_q;
    logic [1:0]       pad_q;
    logic [LEN_W-1:0] idx_q, len_q;
    fmt_e             fmt_q;
    out_tag_t         tag_q;
    logic             take;
    logic             last_pay;

    assign accept_o   = (ph_q == PH_IDLE) && start_i && rx_busy_i && !cs_high_i;
    assign oversize_o = (int'(len_i) > MAX_LEN);
    assign take       = next_i && !cs_high_i && (ph_q != PH_IDLE);
    assign last_pay   = ((idx_q + LEN_W'(1)) == len_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            pad_q <= '0;
            idx_q <= '0;
            len_q <= '0;
            fmt_q <= FMT_LEGACY;
            tag_q <= '{vld: 1'b0, kind: K_PAD};
        end else if (cs_high_i) begin
            ph_q      <= PH_IDLE;
            tag_q.vld <= 1'b0;
        end else if (accept_o) begin
            ph_q      <= PH_PAD;
            fmt_q     <= fmt_e'(fmt_i);
            pad_q     <= fmt_i ? PKT_PAD_LAST : LEG_PAD_LAST;
            idx_q     <= '0;
            len_q     <= oversize_o ? '0 : len_i;
            tag_q.vld <= 1'b0;
        end else if (take) begin
            tag_q.vld <= 1'b1;
            case (ph_q)
                PH_PAD: begin
                    tag_q.kind <= K_PAD;
                    if (pad_q == '0) ph_q <= PH_FRM;
                    else             pad_q <= pad_q - 2'd1;
                end
                PH_FRM: begin
                    tag_q.kind <= K_FRM;
                    if (fmt_q == FMT_LEGACY) ph_q <= PH_STAT;
                    else                     ph_q <= (len_q == '0) ? PH_END : PH_PAY;
                end
                PH_STAT: begin
                    tag_q.kind <= K_STAT;
                    ph_q       <= PH_LEN;
                end
                PH_LEN: begin
                    tag_q.kind <= K_LEN;
                    ph_q       <= (len_q == '0) ? PH_SUM : PH_PAY;
                end
                PH_PAY: begin
                    tag_q.kind <= K_PAY;
                    idx_q      <= idx_q + LEN_W'(1);
                    if (last_pay) ph_q <= (fmt_q == FMT_LEGACY) ? PH_SUM : PH_END;
                end
                PH_SUM: begin
                    tag_q.kind <= K_SUM;
                    ph_q       <= PH_END;
                end
                default: begin
                    tag_q.kind <= K_END;
                    ph_q       <= PH_TAIL;
                end
            endcase
        end else begin
            tag_q.vld <= 1'b0;
        end
    end

    assign tag_o    = tag_q;
    assign idx_o    = idx_q;
    assign len_o    = len_q;
    assign fmt_o    = fmt_q;
    assign active_o = (ph_q != PH_IDLE);

    assert_pay_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_PAY) |-> (idx_q < len_q));

    assert_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        ((ph_q == PH_IDLE) && start_i && !rx_busy_i) |=> (ph_q == PH_IDLE));
endmodule

// File: rtl/rsp_frame_ser.sv
module rsp_frame_ser
    import rsp_pkg::*;
#(
    parameter  int MAX_LEN = 544,
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             fmt_i,
    input  logic [7:0]       status_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             rx_busy_i,
    input  logic             cs_high_i,
    input  logic             next_i,
    output logic [LEN_W-1:0] rd_addr_o,
    input  logic [7:0]       rd_data_i,
    output logic [7:0]       byte_o,
    output logic             byte_vld_o,
    output logic             active_o
);
    logic             accept, oversize;
    out_tag_t         tag;
    logic [LEN_W-1:0] idx, len_q;
    fmt_e             fmt_q;
    logic [7:0]       status_q, sum, st_eff, len_eff;

    rsp_seq #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .fmt_i     (fmt_i),
        .len_i     (len_i),
        .rx_busy_i (rx_busy_i),
        .cs_high_i (cs_high_i),
        .next_i    (next_i),
        .accept_o  (accept),
        .oversize_o(oversize),
        .tag_o     (tag),
        .idx_o     (idx),
        .len_o     (len_q),
        .fmt_o     (fmt_q),
        .active_o  (active_o)
    );

    assign st_eff  = oversize ? ST_BADRSP : status_i;
    assign len_eff = oversize ? 8'h00 : len_i[7:0];

    always_ff @(posedge clk) begin
        if (rst)         status_q <= '0;
        else if (accept) status_q <= st_eff;
    end

    rsp_csum u_csum (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .init_i (st_eff + len_eff),
        .add_i  (tag.vld && (tag.kind == K_PAY)),
        .data_i (rd_data_i),
        .sum_o  (sum)
    );

    assign rd_addr_o  = idx;
    assign byte_vld_o = tag.vld;

    always_comb begin
        case (tag.kind)
            K_PAY:   byte_o = rd_data_i;
            K_SUM:   byte_o = sum;
            default: byte_o = const_byte(tag.kind, status_q, len_q[7:0]);
        endcase
    end

    assert_vld_after_req_R9: assert property (@(posedge clk) disable iff (rst)
        byte_vld_o |-> $past(next_i));

    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (rst)
        cs_high_i |=> (!active_o && !byte_vld_o));

    assert_status_legacy_only_R4: assert property (@(posedge clk) disable iff (rst)
        (byte_vld_o && (tag.kind == K_STAT || tag.kind == K_SUM)) |-> (fmt_q == FMT_LEGACY));

    assert_idle_no_byte_R10: assert property (@(posedge clk) disable iff (rst)
        (!active_o && next_i) |=> !byte_vld_o);
endmodule

// File: tb/tb_rsp_frame_ser.sv
module tb_rsp_frame_ser;
    localparam int MAX_LEN = 544;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);

    logic             clk = 1'b0;
    logic             rst, start_i, fmt_i, rx_busy_i, cs_high_i, next_i;
    logic [7:0]       status_i, rd_data_i, byte_o;
    logic [LEN_W-1:0] len_i, rd_addr_o;
    logic             byte_vld_o, active_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    int exp_b [0:1200];
    int got_b [0:1200];

    always #5 clk = ~clk;

    rsp_frame_ser #(.MAX_LEN(MAX_LEN)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .fmt_i(fmt_i),
        .status_i(status_i), .len_i(len_i), .rx_busy_i(rx_busy_i),
        .cs_high_i(cs_high_i), .next_i(next_i), .rd_addr_o(rd_addr_o),
        .rd_data_i(rd_data_i), .byte_o(byte_o), .byte_vld_o(byte_vld_o),
        .active_o(active_o)
    );

    function automatic int buf_val(int a);
        return (a * 37 + 11) & 255;
    endfunction

    always_ff @(posedge clk) rd_data_i <= 8'(buf_val(int'(rd_addr_o)));

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic frame(input bit fmt, input int st, input int len, input int gap, input string req);
        int n = 0;
        int eff_len, eff_st, sum, total, issued, ng, sum_idx, end_idx;
        bit over = (len > MAX_LEN);
        eff_len = over ? 0 : len;
        eff_st  = over ? 12 : st;
        sum_idx = -1;
        if (!fmt) begin
            exp_b[n++] = 'hFA; exp_b[n++] = 'hEC;
            exp_b[n++] = eff_st; exp_b[n++] = eff_len & 255;
            sum = eff_st + (eff_len & 255);
            for (int i = 0; i < eff_len; i++) begin
                exp_b[n++] = buf_val(i);
                sum += buf_val(i);
            end
            sum_idx = n;
            exp_b[n++] = sum & 255;
        end else begin
            for (int i = 0; i < 3; i++) exp_b[n++] = 'hFA;
            exp_b[n++] = 'hEC;
            for (int i = 0; i < eff_len; i++) exp_b[n++] = buf_val(i);
        end
        end_idx = n;
        for (int i = 0; i < 3; i++) exp_b[n++] = 'hED;
        total = n;

        @(negedge clk);
        start_i = 1'b1; fmt_i = fmt; status_i = 8'(st); len_i = LEN_W'(len);
        @(negedge clk);
        start_i = 1'b0;
        chk(active_o == 1'b1, "R6 start accepted", int'(active_o), 1);

        issued = 0; ng = 0;
        for (int c = 0; c < total * (gap + 1) + 2; c++) begin
            if (byte_vld_o) begin
                if (ng <= 1200) got_b[ng] = int'(byte_o);
                ng++;
            end
            if (issued < total && (c % (gap + 1)) == 0) begin
                next_i = 1'b1; issued++;
            end else next_i = 1'b0;
            @(negedge clk);
        end
        next_i = 1'b0;
        chk(ng == total, {req, " R9 byte count"}, ng, total);
        for (int i = 0; i < total && i < ng; i++) begin
            if (i == sum_idx)      chk(got_b[i] == exp_b[i], "R3 checksum", got_b[i], exp_b[i]);
            else if (i > end_idx)  chk(got_b[i] == exp_b[i], "R5 filler", got_b[i], exp_b[i]);
            else                   chk(got_b[i] == exp_b[i], req, got_b[i], exp_b[i]);
        end

        cs_high_i = 1'b1;
        @(negedge clk);
        cs_high_i = 1'b0;
        chk(active_o == 1'b0, "R8 idle after chip select", int'(active_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; fmt_i = 1'b0; status_i = '0; len_i = '0;
        rx_busy_i = 1'b1; cs_high_i = 1'b0; next_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(byte_vld_o == 1'b0, "R1 valid low after reset", int'(byte_vld_o), 0);
        chk(active_o == 1'b0, "R1 idle after reset", int'(active_o), 0);

        // R10: requests while idle
        next_i = 1'b1;
        @(negedge clk);
        chk(byte_vld_o == 1'b0, "R10 idle request", int'(byte_vld_o), 0);
        @(negedge clk);
        next_i = 1'b0;
        chk(byte_vld_o == 1'b0, "R10 idle request", int'(byte_vld_o), 0);

        // R2, R4, R9: both formats, lengths and request spacing
        for (int g = 0; g < 2; g++)
            for (int l = 0; l < 10; l++) begin
                frame(1'b0, (l * 13 + 5) & 255, l, g, "R2 legacy stream");
                frame(1'b1, 0, l, g, "R4 packet stream");
            end

        // R7: boundary and oversize lengths
        frame(1'b0, 'h33, 544, 0, "R7 legacy max length");
        frame(1'b1, 0, 544, 1, "R7 packet max length");
        frame(1'b0, 'h01, 545, 0, "R7 legacy oversize");
        frame(1'b1, 0, 1023, 0, "R7 packet oversize");

        // R6: start while receive side not processing
        rx_busy_i = 1'b0;
        @(negedge clk);
        start_i = 1'b1; fmt_i = 1'b0; len_i = LEN_W'(4);
        @(negedge clk);
        start_i = 1'b0;
        chk(active_o == 1'b0, "R6 start ignored", int'(active_o), 0);
        next_i = 1'b1;
        @(negedge clk);
        next_i = 1'b0;
        chk(byte_vld_o == 1'b0, "R6 no byte after ignored start", int'(byte_vld_o), 0);
        rx_busy_i = 1'b1;

        // R8: abort in the middle of a response
        @(negedge clk);
        start_i = 1'b1; fmt_i = 1'b0; status_i = 8'h21; len_i = LEN_W'(6);
        @(negedge clk);
        start_i = 1'b0;
        next_i = 1'b1;
        repeat (3) @(negedge clk);
        chk(byte_vld_o == 1'b1, "R8 bytes before abort", int'(byte_vld_o), 1);
        cs_high_i = 1'b1;
        @(negedge clk);
        cs_high_i = 1'b0;
        chk(byte_vld_o == 1'b0, "R8 request at abort dropped", int'(byte_vld_o), 0);
        chk(active_o == 1'b0, "R8 idle after abort", int'(active_o), 0);
        @(negedge clk);
        chk(byte_vld_o == 1'b0, "R8 no byte after abort", int'(byte_vld_o), 0);
        next_i = 1'b0;

        // R2 again after abort: clean restart
        frame(1'b0, 'h7E, 3, 0, "R2 restart after abort");

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule